// File: doc/BRIEF.md
# Slow-Strobe Sample to Stream Master

This block carries 32-bit raw samples from a slow producer into a fast stream clock domain. The producer marks each new word with a rising edge on its own slow capture clock. The block does not run logic on that clock. It samples the capture clock as an ordinary input, passes it through a synchronizer chain, and turns each rising edge into a single-cycle capture pulse. On that pulse the current data word is copied into a holding register. The held word is then offered as one stream beat until the downstream sink takes it.

Each sample forms a packet of one beat, so every byte-keep bit is set and the last-beat marker is set on every beat. The beat controller is a two-state machine. **ST_EMPTY** means no word is held. **ST_FULL** means a word is on the bus with valid high. It has four named transitions:
- **T_LOAD** (ST_EMPTY to ST_FULL): a capture pulse arrives.
- **T_TAKE** (ST_FULL to ST_EMPTY): a handshake completes and no pulse arrives.
- **T_RELOAD** (ST_FULL to ST_FULL): a handshake and a pulse arrive in the same cycle, and the new word replaces the one just taken.
- **T_DROP** (ST_FULL to ST_FULL): a pulse arrives with no handshake. The new sample is discarded and the sticky overflow flag is set.

Top module: `strobe_axis_src`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, m_tvalid is 0 and ovf_o is 0.
- R2: A rising edge on smp_clk_i raises m_tvalid within 4 clock cycles, whatever the level of m_tready. m_tdata then equals the value smp_data_i had when the edge was taken.
- R3: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata stays unchanged in the next cycle.
- R4: Each sample edge produces exactly one handshake (m_tvalid and m_tready both 1). After a handshake with no new edge, m_tvalid is 0 in the next cycle.
- R5: A new edge that arrives while a word is held and not being accepted is dropped. The presented m_tdata is unchanged, ovf_o becomes 1, and the dropped word never appears as a beat.
- R6: Once set, ovf_o stays 1 until rst_n is driven low.
- R7: Whenever m_tvalid is 1, m_tkeep is 4'b1111 and m_tlast is 1.
- R8: An edge detected in the same cycle as a handshake loads the new word. In the next cycle m_tvalid is 1, m_tdata is the new word, and ovf_o stays 0.
- R9: A falling edge on smp_clk_i produces no beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_clk_i | input | 1 | Slow capture clock, used as a strobe |
| smp_data_i | input | 32 | Raw sample word; changes on the strobe's rising edge |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | 32 | Beat data |
| m_tkeep | output | 4 | Byte keep, all ones |
| m_tlast | output | 1 | Last-beat marker, always 1 |
| ovf_o | output | 1 | Sticky flag: a sample was dropped |

## Verification
Two functions can fall in the same cycle: the sink completing a handshake and the synchronizer reporting a new edge. The bench provokes this by holding a word under back-pressure. It then raises the strobe and raises m_tready so that the handshake lands on the edge where the capture pulse is two flops deep. The outcome is judged at the ports. The next cycle must present the new word with the overflow flag still clear. A second handshake must then drain it, so that both words appear once in the beat log. The dropped-sample case, where the edge meets a stall instead, is checked the same way: the held word stays on the bus and the dropped word never reaches the log.

// File: rtl/strobe_axis_pkg.sv
package strobe_axis_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } beat_state_e;

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);

    localparam int CHAIN_W = STAGES + 1;

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], strobe_i};
        end
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];

    // R9: a rise pulse lasts exactly one cycle, so a level never counts twice
    p_pulse_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/strobe_beat_ctrl.sv
module strobe_beat_ctrl
    import strobe_axis_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ovf_o
);

    beat_state_e state, state_nxt;
    logic        load;
    logic        drop;
    logic [DATA_W-1:0] hold_q;
    logic        ovf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: T_LOAD, T_TAKE, T_RELOAD, T_DROP
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        drop      = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (rise_i) begin
                    load      = 1'b1;          // T_LOAD
                    state_nxt = ST_FULL;
                end
            end
            ST_FULL: begin
                if (ready_i) begin
                    if (rise_i) begin
                        load = 1'b1;           // T_RELOAD
                    end else begin
                        state_nxt = ST_EMPTY;  // T_TAKE
                    end
                end else if (rise_i) begin
                    drop = 1'b1;               // T_DROP
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (drop) begin
            ovf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        valid_o = (state == ST_FULL);
        data_o  = hold_q;
        ovf_o   = ovf_q;
    end

    // R2: a pulse seen while empty puts the sampled word on the bus
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && rise_i) |=> (valid_o && data_o == $past(din_i)));

    // R3: a stalled beat holds still
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

    // R4: an accepted beat with no new pulse empties the holder
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !rise_i) |=> !valid_o);

    // R5: a pulse during a stall is dropped and flagged
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && rise_i) |=> (valid_o && $stable(data_o) && ovf_o));

    // R6: overflow is sticky
    p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8: a pulse that meets a handshake reloads without flagging
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && rise_i && !ovf_o) |=>
            (valid_o && data_o == $past(din_i) && !ovf_o));

endmodule

// File: rtl/strobe_axis_src.sv
module strobe_axis_src #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_clk_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              m_tready,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic              m_tlast,
    output logic              ovf_o
);

    localparam int KEEP_W = DATA_W / 8;

    logic rise;

    strobe_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (smp_clk_i),
        .rise_o   (rise)
    );

    strobe_beat_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .din_i   (smp_data_i),
        .ready_i (m_tready),
        .valid_o (m_tvalid),
        .data_o  (m_tdata),
        .ovf_o   (ovf_o)
    );

    // one-beat packets: every byte kept, every beat last
    assign m_tkeep = {KEEP_W{1'b1}};
    assign m_tlast = 1'b1;

endmodule

// File: tb/strobe_axis_src_tb.sv
`timescale 1ns / 1ps
module strobe_axis_src_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_clk;
    logic [31:0] smp_data;
    logic        tready;
    logic        tvalid;
    logic [31:0] tdata;
    logic [3:0]  tkeep;
    logic        tlast;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] beats [0:63];
    int          nbeat = 0;

    always #10 clk = ~clk;

    strobe_axis_src dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_clk_i  (smp_clk),
        .smp_data_i (smp_data),
        .m_tready   (tready),
        .m_tvalid   (tvalid),
        .m_tdata    (tdata),
        .m_tkeep    (tkeep),
        .m_tlast    (tlast),
        .ovf_o      (ovf)
    );

    // beat log
    always @(posedge clk) begin
        if (rst_n && tvalid && tready) begin
            if (nbeat < 64) beats[nbeat] <= tdata;
            nbeat <= nbeat + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        smp_clk  = 1'b0;
        smp_data = '0;
        tready   = 1'b0;
        tick(3);
        chk("R1 valid in reset", {31'b0, tvalid}, 32'd0);
        chk("R1 ovf in reset", {31'b0, ovf}, 32'd0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 valid after reset", {31'b0, tvalid}, 32'd0);
        chk("R1 ovf after reset", {31'b0, ovf}, 32'd0);
        nbeat = 0;
    endtask

    // raise strobe with a new word, return the cycles until valid
    task automatic strobe_up(input logic [31:0] w, output int lat);
        smp_data = w;
        smp_clk  = 1'b1;
        lat = 0;
        while (!tvalid && lat < 8) begin
            tick(1);
            lat++;
        end
    endtask

    task automatic t_basic();
        int lat;
        strobe_up(32'hA5A5_0001, lat);
        chk("R2 valid latency ok", {31'b0, (lat <= 4)}, 32'd1);
        chk("R2 data", tdata, 32'hA5A5_0001);
        chk("R7 keep", {28'b0, tkeep}, 32'hF);
        chk("R7 last", {31'b0, tlast}, 32'd1);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            chk("R3 stall valid", {31'b0, tvalid}, 32'd1);
            chk("R3 stall data", tdata, 32'hA5A5_0001);
        end
        tready = 1'b1;
        tick(1);
        tready = 1'b0;
        chk("R4 empty after take", {31'b0, tvalid}, 32'd0);
        chk("R4 one beat", nbeat, 32'd1);
        smp_clk = 1'b0;
        tick(8);
        chk("R9 no beat on fall", {31'b0, tvalid}, 32'd0);
        chk("R9 beat count", nbeat, 32'd1);
    endtask

    task automatic t_stream();
        int base;
        int lat;
        base = nbeat;
        tready = 1'b1;
        for (int s = 0; s < 6; s++) begin
            smp_data = 32'h1000 + s;
            smp_clk  = 1'b1;
            tick(8);
            smp_clk  = 1'b0;
            tick(8);
        end
        chk("R4 stream count", nbeat - base, 32'd6);
        for (int s = 0; s < 6; s++)
            chk("R4 stream data", beats[base + s], 32'h1000 + s);
        tready = 1'b0;
        lat = 0;
    endtask

    task automatic t_backpressure();
        int base;
        int cyc;
        base = nbeat;
        cyc  = 0;
        for (int s = 0; s < 5; s++) begin
            smp_data = 32'hB000 + s;
            smp_clk  = 1'b1;
            for (int k = 0; k < 16; k++) begin
                if (k == 8) smp_clk = 1'b0;
                tready = ((cyc % 4) == 3);
                if (tvalid && !tready) begin
                    @(posedge clk);
                    @(negedge clk);
                    cyc++;
                    if (!tready) begin
                        chk("R3 bp valid held", {31'b0, tvalid}, 32'd1);
                    end
                end else begin
                    tick(1);
                    cyc++;
                end
            end
        end
        tready = 1'b1;
        tick(4);
        tready = 1'b0;
        chk("R4 bp count", nbeat - base, 32'd5);
        for (int s = 0; s < 5; s++)
            chk("R4 bp data", beats[base + s], 32'hB000 + s);
        chk("R5 no ovf under light bp", {31'b0, ovf}, 32'd0);
    endtask

    task automatic t_overflow();
        int lat;
        int base;
        base = nbeat;
        tready = 1'b0;
        strobe_up(32'hC0DE_0001, lat);
        chk("R2 ovf-case capture", tdata, 32'hC0DE_0001);
        smp_clk = 1'b0;
        tick(8);
        smp_data = 32'hDEAD_0002;
        smp_clk  = 1'b1;
        tick(8);
        chk("R5 held word kept", tdata, 32'hC0DE_0001);
        chk("R5 ovf set", {31'b0, ovf}, 32'd1);
        tready = 1'b1;
        tick(1);
        tready = 1'b0;
        chk("R5 empty after take", {31'b0, tvalid}, 32'd0);
        smp_clk = 1'b0;
        tick(8);
        chk("R5 dropped word absent", nbeat - base, 32'd1);
        chk("R5 beat is held word", beats[base], 32'hC0DE_0001);
        tready = 1'b1;
        for (int s = 0; s < 2; s++) begin
            smp_data = 32'hE000 + s;
            smp_clk  = 1'b1;
            tick(8);
            smp_clk  = 1'b0;
            tick(8);
        end
        tready = 1'b0;
        chk("R6 ovf sticky", {31'b0, ovf}, 32'd1);
        do_reset();
        chk("R6 ovf cleared by reset", {31'b0, ovf}, 32'd0);
    endtask

    task automatic t_same_cycle();
        int lat;
        int base;
        base = nbeat;
        tready = 1'b0;
        strobe_up(32'h5A5A_0003, lat);
        chk("R2 pre-reload capture", tdata, 32'h5A5A_0003);
        smp_clk = 1'b0;
        tick(8);
        // strobe up before edge k; pulse is in cycle k+1..k+2, capture at k+2
        smp_data = 32'h6B6B_0004;
        smp_clk  = 1'b1;
        tick(2);
        tready = 1'b1;
        tick(1);
        chk("R8 valid after reload", {31'b0, tvalid}, 32'd1);
        chk("R8 new word", tdata, 32'h6B6B_0004);
        chk("R8 no ovf", {31'b0, ovf}, 32'd0);
        tick(1);
        tready = 1'b0;
        chk("R8 drained", {31'b0, tvalid}, 32'd0);
        chk("R8 both beats", nbeat - base, 32'd2);
        chk("R8 first beat", beats[base], 32'h5A5A_0003);
        chk("R8 second beat", beats[base + 1], 32'h6B6B_0004);
        smp_clk = 1'b0;
        tick(8);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_basic();
        t_stream();
        t_backpressure();
        t_overflow();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule